// File: doc/BRIEF.md
# Interrupt Source Mode Gate

This block holds the per-source interrupt state for a small group of wired interrupt lines: a pending flag, an enable flag and the last sampled input level for each source. Sources are numbered from 1 to `NUM_SRC`; there is no source 0. Each source has its own configuration word that either picks a sensing mode (inactive, detached, rising edge, falling edge, level high, level low) or marks the source as handed to a child controller, in which case the word carries a child index instead.

Raw input lines pass through a two-flop synchronizer. Edge and level sensing then set pending. Software reaches the block through a 32-bit register port and can set or clear pending or enable either as bitmap words or by writing a single source number. Writes that would set or clear pending are filtered by the sensing mode and by the live input level. The block drives one flag per source that is high when that source is both pending and enabled, and it returns the polarity-corrected input level through a readback word. A further number port byte-swaps its value before use.

Top module: `irq_src_gate`

## Requirements
- R1: After reset, every configuration word, pending bit, enable bit, `irq_ready_o` bit and readback word is zero.
- R2: A configuration write with bit 10 set stores bit 10 together with bits 9:0 as a child index. Without bit 10 it stores only bits 2:0 as the mode: 0 inactive, 1 detached, 4 rising edge, 5 falling edge, 6 level high, 7 level low. Modes 2 and 3 are stored as 0. Reading the configuration address (4 × source) returns the stored word.
- R3: A configuration write whose stored value is zero or has bit 10 set clears that source's pending and enable bits on the same clock edge.
- R4: Set and clear of pending or enable do nothing for source number 0, for numbers above `NUM_SRC`, and for sources that are inactive or delegated.
- R5: In rising-edge mode, pending is set when the synchronized input changes from 0 to 1. In falling-edge mode, pending is set when it changes from 1 to 0. The change shows in state three clock edges after the raw pin changes.
- R6: In level modes (6 and 7), a software clear of pending has no effect. A software set is accepted only when `msg_mode_i` is 1 and the stored input is at its asserted level. Any sample at the asserted level sets pending.
- R7: In detached and edge modes, software sets and clears pending through bitmap words (0x400 + 4w set, 0x480 + 4w clear) and through number registers (0x600 set, 0x604 clear). Bit i of word w addresses source 32w + i.
- R8: The readback at 0x480 + 4w returns, for each source, the stored input XOR an inversion flag. The flag is 1 in modes 5 and 7. Inactive and delegated sources read 0.
- R9: A write to 0x610 byte-swaps the 32-bit value and then uses the result as a set-pending source number.
- R10: If a software set or a software clear of pending lands on the same clock edge as a sensed edge that sets pending, the source ends up pending.
- R11: `irq_ready_o[s]` is 1 exactly when source s is both pending and enabled, and it is updated on the same edge as those bits.
- R12: Software sets and clears enable through bitmap words (0x500 + 4w set, 0x580 + 4w clear) and through number registers (0x608 set, 0x60C clear). Reading 0x500 + 4w returns the enable bits and reading 0x400 + 4w returns the pending bits. All register reads appear on `reg_rdata_o` one edge after `reg_re_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_mode_i | input | 1 | When high, software set of pending is allowed for level-mode sources |
| irq_raw_i | input | NUM_SRC | Raw interrupt lines; bit s-1 carries source s |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Byte address; must be word-aligned |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_ready_o | output | NUM_SRC | Per-source pending-and-enabled flag; bit s-1 is source s |

## Verification
Two things can change a source's pending bit on the same clock edge: a register write and a sensed input edge. When they collide, the edge must not be lost. The bench counts the delay through the synchronizer and the stored input bit, which is three edges from the pin. It places a clear-pending-by-number write so that it is sampled on exactly the edge where a rising transition sets pending, and it requires the source to read back as pending afterwards. A later clear with no edge present then has to succeed. The same alignment is repeated with a set-by-number write, and the source must still be pending.

// File: rtl/irq_src_gate_pkg.sv
package irq_src_gate_pkg;

  localparam int ADDR_W  = 12;
  localparam int CFG_W   = 11;
  localparam int DLG_BIT = 10;

  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_DETACH = 3'd1,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_HIGH   = 3'd6,
    SM_LOW    = 3'd7
  } sense_e;

  // register regions selected by address bits 11:7
  localparam logic [4:0] RG_SETP = 5'd8;   // 0x400
  localparam logic [4:0] RG_CLRP = 5'd9;   // 0x480
  localparam logic [4:0] RG_SETE = 5'd10;  // 0x500
  localparam logic [4:0] RG_CLRE = 5'd11;  // 0x580
  localparam logic [4:0] RG_NUM  = 5'd12;  // 0x600

  // number-command slots selected by address bits 6:2 inside RG_NUM
  localparam logic [4:0] NUM_SETP      = 5'd0;
  localparam logic [4:0] NUM_CLRP      = 5'd1;
  localparam logic [4:0] NUM_SETE      = 5'd2;
  localparam logic [4:0] NUM_CLRE      = 5'd3;
  localparam logic [4:0] NUM_SETP_SWAP = 5'd4;

  function automatic logic [31:0] swap_bytes(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // keep delegate plus child index, or the mode alone; reserved modes become inactive
  function automatic logic [CFG_W-1:0] legalize_cfg(input logic [CFG_W-1:0] v);
    if (v[DLG_BIT])
      return v;
    else if (v[2:1] == 2'b01)
      return '0;
    else
      return {{(CFG_W-3){1'b0}}, v[2:0]};
  endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_src_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             msg_mode,
  input  logic             in_sync,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             set_pend,
  input  logic             clr_pend,
  input  logic             set_en,
  input  logic             clr_en,
  output logic [CFG_W-1:0] cfg_q,
  output logic             pend_q,
  output logic             en_q,
  output logic             rect,
  output logic             ready_q
);
  logic       in_q;
  logic [2:0] mode;
  logic       active, is_level, inv, hw_set, sw_set_ok, sw_clr_ok, cfg_kill;
  logic       pend_n, en_n;

  assign mode     = cfg_q[2:0];
  assign active   = !cfg_q[DLG_BIT] && (mode != SM_OFF);
  assign is_level = active && ((mode == SM_HIGH) || (mode == SM_LOW));
  assign inv      = (mode == SM_FALL) || (mode == SM_LOW);
  assign rect     = active && (in_q ^ inv);
  assign cfg_kill = cfg_we && ((cfg_wdata == '0) || cfg_wdata[DLG_BIT]);

  always_comb begin
    hw_set = 1'b0;
    if (active) begin
      case (mode)
        SM_RISE: hw_set = in_sync && !in_q;
        SM_FALL: hw_set = !in_sync && in_q;
        SM_HIGH: hw_set = in_sync;
        SM_LOW:  hw_set = !in_sync;
        default: hw_set = 1'b0;
      endcase
    end
  end

  assign sw_set_ok = active && set_pend && (!is_level || (msg_mode && (in_q ^ inv)));
  assign sw_clr_ok = active && clr_pend && !is_level;

  always_comb begin
    if (cfg_kill) begin
      pend_n = 1'b0;
      en_n   = 1'b0;
    end else begin
      pend_n = (pend_q && !sw_clr_ok) || sw_set_ok || hw_set;
      en_n   = active ? ((en_q && !clr_en) || set_en) : en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      in_q    <= 1'b0;
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      in_q    <= in_sync;
      pend_q  <= pend_n;
      en_q    <= en_n;
      ready_q <= pend_n && en_n;
    end
  end

  // R3
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && ((cfg_wdata == '0) || cfg_wdata[DLG_BIT])) |=> (!pend_q && !en_q));

  // R4
  inactive_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> (!pend_q && !en_q));

  // R5
  edge_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (active && (mode == SM_RISE) && in_sync && !in_q && !cfg_we) |=> pend_q);

  // R6
  level_clr_ign_chk: assert property (@(posedge clk) disable iff (rst)
    (is_level && clr_pend && pend_q && !cfg_we) |=> pend_q);

  // R11
  ready_match_chk: assert property (@(posedge clk) disable iff (rst)
    ready_q == (pend_q && en_q));

endmodule

// File: rtl/irq_src_regif.sv
module irq_src_regif
  import irq_src_gate_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic                          re,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [31:0]                   wdata,
  input  logic [NUM_SRC:1][CFG_W-1:0]   cfg_q,
  input  logic [NUM_SRC:1]              pend_q,
  input  logic [NUM_SRC:1]              en_q,
  input  logic [NUM_SRC:1]              rect_q,
  output logic [NUM_SRC:1]              cfg_we,
  output logic [NUM_SRC:1]              set_pend,
  output logic [NUM_SRC:1]              clr_pend,
  output logic [NUM_SRC:1]              set_en,
  output logic [NUM_SRC:1]              clr_en,
  output logic [CFG_W-1:0]              cfg_wdata,
  output logic [31:0]                   rdata
);
  localparam int NW = (NUM_SRC + 32) / 32;
  localparam int PW = NW * 32;

  logic        aligned, is_cfg;
  logic [4:0]  region, word;
  logic [7:0]  slot;
  logic [31:0] num_val, rd_n;
  logic [PW-1:0] pend_pad, en_pad, rect_pad;

  assign aligned   = (addr[1:0] == 2'b00);
  assign is_cfg    = (addr[11:10] == 2'b00);
  assign region    = addr[11:7];
  assign word      = addr[6:2];
  assign slot      = addr[9:2];
  assign num_val   = (word == NUM_SETP_SWAP) ? swap_bytes(wdata) : wdata;
  assign cfg_wdata = legalize_cfg(wdata[CFG_W-1:0]);

  always_comb begin
    cfg_we   = '0;
    set_pend = '0;
    clr_pend = '0;
    set_en   = '0;
    clr_en   = '0;
    if (we && aligned) begin
      for (int s = 1; s <= NUM_SRC; s++) begin
        if (is_cfg) begin
          cfg_we[s] = (slot == 8'(s));
        end else begin
          case (region)
            RG_SETP: set_pend[s] = (word == 5'(s / 32)) && wdata[s % 32];
            RG_CLRP: clr_pend[s] = (word == 5'(s / 32)) && wdata[s % 32];
            RG_SETE: set_en[s]   = (word == 5'(s / 32)) && wdata[s % 32];
            RG_CLRE: clr_en[s]   = (word == 5'(s / 32)) && wdata[s % 32];
            RG_NUM: begin
              case (word)
                NUM_SETP, NUM_SETP_SWAP: set_pend[s] = (num_val == 32'(s));
                NUM_CLRP: clr_pend[s] = (num_val == 32'(s));
                NUM_SETE: set_en[s]   = (num_val == 32'(s));
                NUM_CLRE: clr_en[s]   = (num_val == 32'(s));
                default: ;
              endcase
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    pend_pad = '0;
    en_pad   = '0;
    rect_pad = '0;
    pend_pad[NUM_SRC:1] = pend_q;
    en_pad[NUM_SRC:1]   = en_q;
    rect_pad[NUM_SRC:1] = rect_q;
  end

  always_comb begin
    rd_n = '0;
    if (aligned) begin
      if (is_cfg) begin
        for (int s = 1; s <= NUM_SRC; s++)
          if (slot == 8'(s)) rd_n = 32'(cfg_q[s]);
      end else begin
        for (int w = 0; w < NW; w++) begin
          if (word == 5'(w)) begin
            case (region)
              RG_SETP: rd_n = pend_pad[w*32 +: 32];
              RG_CLRP: rd_n = rect_pad[w*32 +: 32];
              RG_SETE: rd_n = en_pad[w*32 +: 32];
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_n;
  end

endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
  import irq_src_gate_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msg_mode_i,
  input  logic [NUM_SRC:1]   irq_raw_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic [NUM_SRC:1]   irq_ready_o
);
  logic [NUM_SRC:1]            in_sync;
  logic [NUM_SRC:1][CFG_W-1:0] cfg_q;
  logic [NUM_SRC:1]            pend_q, en_q, rect_q;
  logic [NUM_SRC:1]            cfg_we, set_pend, clr_pend, set_en, clr_en;
  logic [CFG_W-1:0]            cfg_wdata;

  irq_src_sync #(.W(NUM_SRC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_raw_i),
    .q   (in_sync)
  );

  irq_src_regif #(.NUM_SRC(NUM_SRC)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we_i),
    .re        (reg_re_i),
    .addr      (reg_addr_i),
    .wdata     (reg_wdata_i),
    .cfg_q     (cfg_q),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .rect_q    (rect_q),
    .cfg_we    (cfg_we),
    .set_pend  (set_pend),
    .clr_pend  (clr_pend),
    .set_en    (set_en),
    .clr_en    (clr_en),
    .cfg_wdata (cfg_wdata),
    .rdata     (reg_rdata_o)
  );

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .msg_mode  (msg_mode_i),
      .in_sync   (in_sync[g]),
      .cfg_we    (cfg_we[g]),
      .cfg_wdata (cfg_wdata),
      .set_pend  (set_pend[g]),
      .clr_pend  (clr_pend[g]),
      .set_en    (set_en[g]),
      .clr_en    (clr_en[g]),
      .cfg_q     (cfg_q[g]),
      .pend_q    (pend_q[g]),
      .en_q      (en_q[g]),
      .rect      (rect_q[g]),
      .ready_q   (irq_ready_o[g])
    );
  end

endmodule

// File: tb/irq_src_gate_bench.sv
module irq_src_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          msg_mode = 1'b0;
  logic [NS:1]   raw = '0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NS:1]   ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_src_gate #(.NUM_SRC(NS)) u_irq_src_gate (
    .clk         (clk),
    .rst         (rst),
    .msg_mode_i  (msg_mode),
    .irq_raw_i   (raw),
    .reg_we_i    (we),
    .reg_re_i    (re),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_ready_o (ready)
  );

  function automatic logic [11:0] a_cfg(input int s);  return 12'(4 * s);           endfunction
  function automatic logic [11:0] a_setp(input int w); return 12'h400 + 12'(4 * w); endfunction
  function automatic logic [11:0] a_clrp(input int w); return 12'h480 + 12'(4 * w); endfunction
  function automatic logic [11:0] a_sete(input int w); return 12'h500 + 12'(4 * w); endfunction
  function automatic logic [11:0] a_clre(input int w); return 12'h580 + 12'(4 * w); endfunction
  localparam logic [11:0] N_SETP = 12'h600, N_CLRP = 12'h604, N_SETE = 12'h608,
                          N_CLRE = 12'h60C, N_SWAP = 12'h610;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic [11:0] a, input int b, input logic exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, 32'(v[b]), 32'(exp));
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(a_setp(0), v); chk("R1 pending word0", v, 0);
    rd(a_setp(1), v); chk("R1 pending word1", v, 0);
    rd(a_sete(0), v); chk("R1 enable word0", v, 0);
    rd(a_clrp(0), v); chk("R1 readback word0", v, 0);
    rd(a_cfg(5), v);  chk("R1 cfg 5", v, 0);
    chk("R1 ready", 32'(ready), 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(a_cfg(3), 32'h0000_01F4); rd(a_cfg(3), v); chk("R2 mode kept", v, 32'h4);
    wr(a_cfg(4), 32'hFFFF_F6A5); rd(a_cfg(4), v); chk("R2 delegate index", v, 32'h6A5);
    wr(a_cfg(9), 32'h3);         rd(a_cfg(9), v); chk("R2 reserved mode", v, 32'h0);
  endtask

  task automatic t_edges();
    raw[3] = 1'b1; settle();
    chk_bit("R5 rising sets", a_setp(0), 3, 1'b1);
    chk("R11 not enabled", 32'(ready[3]), 0);
    wr(N_SETE, 3);
    chk("R11 ready on enable", 32'(ready[3]), 1);
    chk_bit("R12 enable by number", a_sete(0), 3, 1'b1);
    wr(N_CLRP, 3);
    chk_bit("R7 clear by number", a_setp(0), 3, 1'b0);
    chk("R11 ready drops", 32'(ready[3]), 0);
    wr(a_cfg(5), 5);
    raw[5] = 1'b1; settle();
    chk_bit("R5 falling ignores rise", a_setp(0), 5, 1'b0);
    raw[5] = 1'b0; settle();
    chk_bit("R5 falling sets", a_setp(0), 5, 1'b1);
  endtask

  task automatic t_invalid();
    logic [31:0] v;
    wr(a_cfg(40), 1);
    wr(a_setp(1), 32'hFFFF_FFFF);
    rd(a_setp(1), v); chk("R4 beyond count and inactive", v, 32'h100);
    wr(N_SETP, 0);
    wr(N_SETP, 41);
    chk_bit("R4 source zero", a_setp(0), 0, 1'b0);
    rd(a_setp(1), v); chk("R4 number above count", v, 32'h100);
    wr(N_SETP, 4); wr(N_SETE, 4);
    chk_bit("R4 delegated pending", a_setp(0), 4, 1'b0);
    chk_bit("R4 delegated enable", a_sete(0), 4, 1'b0);
    wr(N_SETE, 30);
    chk_bit("R4 inactive enable", a_sete(0), 30, 1'b0);
  endtask

  task automatic t_cfg_clear();
    wr(a_cfg(6), 1); wr(N_SETP, 6); wr(N_SETE, 6);
    chk("R11 detached ready", 32'(ready[6]), 1);
    wr(a_cfg(6), 0);
    chk_bit("R3 zero cfg clears pending", a_setp(0), 6, 1'b0);
    chk_bit("R3 zero cfg clears enable", a_sete(0), 6, 1'b0);
    chk("R3 ready after zero cfg", 32'(ready[6]), 0);
    wr(a_cfg(7), 1); wr(N_SETP, 7); wr(N_SETE, 7);
    wr(a_cfg(7), 32'h400);
    chk_bit("R3 delegate clears pending", a_setp(0), 7, 1'b0);
    chk_bit("R3 delegate clears enable", a_sete(0), 7, 1'b0);
  endtask

  task automatic t_level();
    wr(a_cfg(8), 6);
    settle();
    chk_bit("R6 level high idle", a_setp(0), 8, 1'b0);
    raw[8] = 1'b1; settle();
    chk_bit("R6 level high sets", a_setp(0), 8, 1'b1);
    raw[8] = 1'b0; settle();
    wr(N_CLRP, 8);
    chk_bit("R6 clear by number ignored", a_setp(0), 8, 1'b1);
    wr(a_clrp(0), 32'h1 << 8);
    chk_bit("R6 clear by bitmap ignored", a_setp(0), 8, 1'b1);
    raw[16] = 1'b1; settle();
    wr(a_cfg(16), 7);
    msg_mode = 1'b1;
    wr(N_SETP, 16);
    chk_bit("R6 set refused while deasserted", a_setp(0), 16, 1'b0);
    msg_mode = 1'b0;
    raw[16] = 1'b0; settle();
    chk_bit("R6 level low sets", a_setp(0), 16, 1'b1);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    raw[10] = 1'b0; raw[11] = 1'b1; raw[12] = 1'b1;
    raw[13] = 1'b1; raw[14] = 1'b1; raw[15] = 1'b1;
    settle();
    wr(a_cfg(10), 5); wr(a_cfg(11), 7); wr(a_cfg(13), 1);
    wr(a_cfg(14), 4); wr(a_cfg(15), 32'h400);
    rd(a_clrp(0), v); chk("R8 rectified mix", v & 32'hFC00, 32'h6400);
    raw[10] = 1'b1; settle();
    rd(a_clrp(0), v); chk("R8 falling mode inverted", v & 32'hFC00, 32'h6000);
  endtask

  task automatic t_swap();
    wr(a_cfg(20), 1); wr(a_cfg(21), 1);
    wr(N_SWAP, 32'h1400_0000);
    wr(N_SWAP, 32'h0000_0015);
    chk_bit("R9 swapped number sets", a_setp(0), 20, 1'b1);
    chk_bit("R9 unswapped value ignored", a_setp(0), 21, 1'b0);
  endtask

  task automatic t_same_cycle();
    wr(a_cfg(22), 4);
    chk_bit("R10 start idle", a_setp(0), 22, 1'b0);
    // raw changes now; state sees the edge on the third rising edge
    raw[22] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(N_CLRP, 22);
    chk_bit("R10 clear meets edge", a_setp(0), 22, 1'b1);
    wr(N_CLRP, 22);
    chk_bit("R10 later clear works", a_setp(0), 22, 1'b0);
    raw[22] = 1'b0; settle();
    raw[22] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(N_SETP, 22);
    chk_bit("R10 set meets edge", a_setp(0), 22, 1'b1);
  endtask

  task automatic t_enable_bitmap();
    wr(a_sete(0), 32'h1 << 13);
    chk_bit("R12 enable bitmap set", a_sete(0), 13, 1'b1);
    wr(a_setp(0), 32'h1 << 13);
    chk_bit("R7 bitmap set pending", a_setp(0), 13, 1'b1);
    chk("R11 ready via bitmaps", 32'(ready[13]), 1);
    wr(a_clre(0), 32'h1 << 13);
    chk_bit("R12 enable bitmap clear", a_sete(0), 13, 1'b0);
    chk("R11 ready after disable", 32'(ready[13]), 0);
    wr(N_SETE, 13); wr(N_CLRE, 13);
    chk_bit("R12 enable number clear", a_sete(0), 13, 1'b0);
    wr(a_clrp(0), 32'h1 << 13);
    chk_bit("R7 bitmap clear pending", a_setp(0), 13, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_edges();
    t_invalid();
    t_cfg_clear();
    t_level();
    t_readback();
    t_swap();
    t_same_cycle();
    t_enable_bitmap();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule